// File: doc/BRIEF.md
# Configuration Stream Command Parser

This block reads a configuration image one byte at a time through a valid/ready input and turns it into register settings and control strobes. It first searches the stream for a 32-bit synchronisation word. After that it reads command bytes. The upper four bits of a command byte select the operation. The lower four bits give the number of argument bytes that follow, and those bytes are assembled most significant byte first. A skippable comment section is also recognised. A CRC-16 runs over every byte the block takes in, and a check command compares an expected value against a snapshot of that CRC.

When a data burst is opened, the block keeps taking bytes and flags each one on `burst_valid`. A downstream store counts the bytes and marks the final one with `burst_last`. The block then consumes a fixed number of trailing bytes and goes back to reading commands. A wake-up action ends parsing with a sticky `done`. An illegal command ends parsing with a sticky `error` and a cause code.

The controller has nine states:
- `ST_HUNT` moves to `ST_CMD` on a sync match, or to `ST_FAULT` when `in_last` arrives without a match.
- `ST_CMD` moves to `ST_CMT_OPEN` on 0xFF, to `ST_FAULT` on an illegal command, and otherwise to `ST_PAYLOAD`.
- `ST_CMT_OPEN` moves to `ST_CMT_SKIP` on 0x00 and otherwise to `ST_FAULT`.
- `ST_CMT_SKIP` returns to `ST_CMD` once the last two bytes are 0x00 then 0xFF.
- `ST_PAYLOAD` goes on its last argument byte to `ST_CMD`, `ST_BURST`, `ST_DONE` or `ST_FAULT`.
- `ST_BURST` moves to `ST_TRAIL` on a byte that carries `burst_last`.
- `ST_TRAIL` returns to `ST_CMD` after the trailing bytes.
- `ST_DONE` and `ST_FAULT` are terminal.

Top module: `cfg_stream_parser`

## Requirements
- R1: Until the last four accepted bytes equal 0x7EAA997E, no byte is decoded as a command. If a byte carrying `in_last` is accepted during the search without completing the match, `error` rises with `err_code` 1.
- R2: A command byte carries its opcode in bits [7:4] and its argument length in bits [3:0]. The legal pairs are opcodes 0, 1 and 5 with length 1, and opcodes 2, 6, 7, 8 and 9 with length 2. Any other command byte except 0xFF sets `error` with `err_code` 2.
- R3: Two-byte arguments are assembled with the first byte as the upper eight bits.
- R4: The command byte 0xFF must be followed by 0x00, or `error` rises with `err_code` 7. Later bytes are ignored until the last two accepted bytes are 0x00 then 0xFF; the opening 0x00 counts, so FF 00 FF is an empty comment.
- R5: Opcode 0 with argument 0x01 pulses `cram_start`, and with 0x03 pulses `bram_start`, for one cycle. Burst bytes are then flagged on `burst_valid` up to and including the byte with `burst_last`. After that, 2 more bytes are consumed without decoding or flagging. Any other action argument except 0x05 and 0x06 gives `err_code` 3.
- R6: Action 0x05 leaves `crc_out` at zero after its byte. Action 0x06 raises `done` and drops `in_ready`.
- R7: Opcode 1 stores the low two bits of its argument in `bank`. An argument above 3 sets the sticky `bank_bad` but not `error`.
- R8: Opcode 5 loads `freq` with argument 0 (low), 1 (medium) or 2 (high). A larger argument gives `err_code` 4.
- R9: The first opcode 6 loads `cram_rows` with its argument plus one, and any later one loads `bram_rows`. Opcode 7 loads `cram_cols`, then `bram_cols`, by the same first/later rule, without the plus one.
- R10: Opcode 8 with argument 0x0000 pulses `wp_reset` for one cycle. With 0x0080 it does nothing. Any other argument gives `err_code` 5.
- R11: Opcode 9 copies argument bit 5 into `warm_boot`. An argument with any bit set under 0xFFDF gives `err_code` 6.
- R12: `crc_out` is a CRC-16 (polynomial 0x1021, MSB first, zero after reset) over every accepted byte.
- R13: Opcode 2 compares its argument with the `crc_out` value held just before its command byte. A mismatch sets the sticky `crc_fail` without setting `error`.
- R14: `done`, `error` and `err_code` hold until reset. While either flag is set, `in_ready` is low and input bytes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| burst_last | input | 1 | Downstream marks the final burst data byte |
| burst_valid | output | 1 | Current input byte is burst data |
| cram_start | output | 1 | Configuration-memory burst start pulse |
| bram_start | output | 1 | Block-memory burst start pulse |
| wp_reset | output | 1 | Block-memory write pointer reset pulse |
| done | output | 1 | Wake-up received, parsing finished |
| error | output | 1 | Parsing stopped on an illegal input |
| err_code | output | 3 | Cause: 1 no sync, 2 command, 3 action, 4 frequency, 5 pointer mode, 6 warm boot, 7 comment |
| crc_fail | output | 1 | A CRC check command mismatched |
| bank_bad | output | 1 | A bank number above 3 was given |
| crc_out | output | 16 | Running CRC |
| bank | output | 2 | Bank register |
| freq | output | 2 | Boot frequency setting |
| warm_boot | output | 1 | Warm-boot enable |
| cram_rows | output | 17 | Configuration-memory row size |
| cram_cols | output | 16 | Configuration-memory column size |
| bram_rows | output | 17 | Block-memory row size |
| bram_cols | output | 16 | Block-memory column size |

## Verification
The assertions assume that `in_data`, `in_last` and `burst_last` are only meaningful when `in_valid` is high, and that every data burst holds at least one byte, so that a `burst_last` eventually comes. The stimulus drives each byte for exactly one cycle and asserts `burst_last` only on a burst byte. It feeds bytes after `done` or `error` only to show that they are refused. Each scenario starts from reset, so the first-versus-later size rule and the sticky flags are seen from a known state.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int CRC_W = 16;
    localparam int ARG_W = 16;

    typedef enum logic [3:0] {
        ST_HUNT, ST_CMD, ST_CMT_OPEN, ST_CMT_SKIP, ST_PAYLOAD,
        ST_BURST, ST_TRAIL, ST_DONE, ST_FAULT
    } st_e;

    typedef enum logic [2:0] {
        ERR_NONE, ERR_NOSYNC, ERR_CMD, ERR_ACTION,
        ERR_FREQ, ERR_WPTR, ERR_WARM, ERR_COMMENT
    } err_e;

    localparam logic [3:0] OP_ACTION = 4'h0;
    localparam logic [3:0] OP_BANK   = 4'h1;
    localparam logic [3:0] OP_CHECK  = 4'h2;
    localparam logic [3:0] OP_FREQ   = 4'h5;
    localparam logic [3:0] OP_ROW    = 4'h6;
    localparam logic [3:0] OP_COL    = 4'h7;
    localparam logic [3:0] OP_WPTR   = 4'h8;
    localparam logic [3:0] OP_WARM   = 4'h9;

    localparam logic [ARG_W-1:0] ACT_CRAM   = 16'h0001;
    localparam logic [ARG_W-1:0] ACT_BRAM   = 16'h0003;
    localparam logic [ARG_W-1:0] ACT_CRCCLR = 16'h0005;
    localparam logic [ARG_W-1:0] ACT_WAKE   = 16'h0006;
endpackage

// File: rtl/cfgp_crc.sv
module cfgp_crc
    import cfgp_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             clr,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc_q
);
    function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c, input logic [7:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '0;
        else if (clr)  crc_q <= '0;
        else if (upd)  crc_q <= step(crc_q, din);
    end

    AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == '0)); // R6
endmodule

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
    parameter logic [31:0] SYNC_WORD = 32'h7EAA997E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic [7:0] din,
    output logic       hit
);
    logic [23:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[15:0], din};
    end

    assign hit = ({hist_q, din} == SYNC_WORD);
endmodule

// File: rtl/cfgp_cmd_check.sv
module cfgp_cmd_check
    import cfgp_pkg::*;
(
    input  logic [7:0] cmd,
    output logic       legal,
    output logic [1:0] len
);
    always_comb begin
        unique case (cmd[7:4])
            OP_ACTION, OP_BANK, OP_FREQ:                  len = 2'd1;
            OP_CHECK, OP_ROW, OP_COL, OP_WPTR, OP_WARM:   len = 2'd2;
            default:                                      len = 2'd0;
        endcase
        legal = (len != 2'd0) && (cmd[3:0] == {2'b00, len});
    end
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
    import cfgp_pkg::*;
#(
    parameter logic [31:0] SYNC_WORD   = 32'h7EAA997E,
    parameter int          SIZE_W      = 16,
    parameter int          TRAIL_BYTES = 2,
    parameter logic [15:0] CRC_POLY    = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              burst_last,
    output logic              burst_valid,
    output logic              cram_start,
    output logic              bram_start,
    output logic              wp_reset,
    output logic              done,
    output logic              error,
    output logic [2:0]        err_code,
    output logic              crc_fail,
    output logic              bank_bad,
    output logic [15:0]       crc_out,
    output logic [1:0]        bank,
    output logic [1:0]        freq,
    output logic              warm_boot,
    output logic [SIZE_W:0]   cram_rows,
    output logic [SIZE_W-1:0] cram_cols,
    output logic [SIZE_W:0]   bram_rows,
    output logic [SIZE_W-1:0] bram_cols
);
    localparam int ROW_W   = SIZE_W + 1;
    localparam int TRAIL_W = $clog2(TRAIL_BYTES + 1);

    st_e              state, state_n;
    err_e             fault_code, pay_err;
    st_e              pay_next;
    logic             accept, sync_hit, cmd_legal, pay_last, crc_clr;
    logic [1:0]       cmd_len, left_q;
    logic [3:0]       op_q;
    logic             two_q, row_seen, col_seen;
    logic [7:0]       hi_q, prev_q;
    logic [TRAIL_W-1:0] trail_q;
    logic [CRC_W-1:0] snap_q;
    logic [ARG_W-1:0] word;

    assign in_ready    = (state != ST_DONE) && (state != ST_FAULT);
    assign accept      = in_valid && in_ready;
    assign burst_valid = (state == ST_BURST) && in_valid;
    assign word        = two_q ? {hi_q, in_data} : {8'h00, in_data};
    assign pay_last    = (state == ST_PAYLOAD) && accept && (left_q == 2'd1);
    assign crc_clr     = pay_last && (op_q == OP_ACTION) && (word == ACT_CRCCLR);

    cfgp_sync #(.SYNC_WORD(SYNC_WORD)) u_sync (
        .clk(clk), .rst_n(rst_n), .shift_en(accept && (state == ST_HUNT)),
        .din(in_data), .hit(sync_hit));

    cfgp_cmd_check u_chk (.cmd(in_data), .legal(cmd_legal), .len(cmd_len));

    cfgp_crc #(.POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .upd(accept), .clr(crc_clr),
        .din(in_data), .crc_q(crc_out));

    // Outcome of a completed argument
    always_comb begin
        pay_next = ST_CMD;
        pay_err  = ERR_NONE;
        case (op_q)
            OP_ACTION: begin
                if (word == ACT_CRAM || word == ACT_BRAM) pay_next = ST_BURST;
                else if (word == ACT_WAKE)                pay_next = ST_DONE;
                else if (word != ACT_CRCCLR) begin pay_next = ST_FAULT; pay_err = ERR_ACTION; end
            end
            OP_FREQ: if (word > 16'd2) begin pay_next = ST_FAULT; pay_err = ERR_FREQ; end
            OP_WPTR: if (word != 16'h0000 && word != 16'h0080) begin
                pay_next = ST_FAULT; pay_err = ERR_WPTR;
            end
            OP_WARM: if ((word & 16'hFFDF) != '0) begin pay_next = ST_FAULT; pay_err = ERR_WARM; end
            default: ;
        endcase
    end

    // Next state
    always_comb begin
        state_n    = state;
        fault_code = ERR_NONE;
        unique case (state)
            ST_HUNT: if (accept) begin
                if (sync_hit)     state_n = ST_CMD;
                else if (in_last) begin state_n = ST_FAULT; fault_code = ERR_NOSYNC; end
            end
            ST_CMD: if (accept) begin
                if (in_data == 8'hFF) state_n = ST_CMT_OPEN;
                else if (!cmd_legal)  begin state_n = ST_FAULT; fault_code = ERR_CMD; end
                else                  state_n = ST_PAYLOAD;
            end
            ST_CMT_OPEN: if (accept) begin
                if (in_data == 8'h00) state_n = ST_CMT_SKIP;
                else begin state_n = ST_FAULT; fault_code = ERR_COMMENT; end
            end
            ST_CMT_SKIP: if (accept && prev_q == 8'h00 && in_data == 8'hFF) state_n = ST_CMD;
            ST_PAYLOAD:  if (pay_last) begin state_n = pay_next; fault_code = pay_err; end
            ST_BURST:    if (accept && burst_last) state_n = ST_TRAIL;
            ST_TRAIL:    if (accept && trail_q == TRAIL_W'(TRAIL_BYTES - 1)) state_n = ST_CMD;
            ST_DONE, ST_FAULT: ;
            default: state_n = ST_FAULT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_n;
    end

    // Outputs and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cram_start <= 1'b0; bram_start <= 1'b0; wp_reset <= 1'b0;
            done <= 1'b0; error <= 1'b0; err_code <= ERR_NONE;
            crc_fail <= 1'b0; bank_bad <= 1'b0; bank <= '0; freq <= '0;
            warm_boot <= 1'b0; cram_rows <= '0; cram_cols <= '0;
            bram_rows <= '0; bram_cols <= '0; row_seen <= 1'b0; col_seen <= 1'b0;
            op_q <= '0; left_q <= '0; two_q <= 1'b0; hi_q <= '0; prev_q <= '0;
            trail_q <= '0; snap_q <= '0;
        end else begin
            cram_start <= 1'b0;
            bram_start <= 1'b0;
            wp_reset   <= 1'b0;
            if (state_n == ST_FAULT && state != ST_FAULT) begin
                error    <= 1'b1;
                err_code <= fault_code;
            end
            if (state_n == ST_DONE && state != ST_DONE) done <= 1'b1;
            if (accept) begin
                case (state)
                    ST_CMD: begin
                        op_q   <= in_data[7:4];
                        left_q <= cmd_len;
                        two_q  <= (cmd_len == 2'd2);
                        snap_q <= crc_out;
                    end
                    ST_CMT_OPEN, ST_CMT_SKIP: prev_q <= in_data;
                    ST_PAYLOAD: begin
                        hi_q   <= in_data;
                        left_q <= left_q - 2'd1;
                        if (pay_last) begin
                            case (op_q)
                                OP_ACTION: begin
                                    cram_start <= (word == ACT_CRAM);
                                    bram_start <= (word == ACT_BRAM);
                                end
                                OP_BANK: begin
                                    bank <= word[1:0];
                                    if (word > 16'd3) bank_bad <= 1'b1;
                                end
                                OP_CHECK: if (word != snap_q) crc_fail <= 1'b1;
                                OP_FREQ:  if (word <= 16'd2) freq <= word[1:0];
                                OP_ROW: begin
                                    if (!row_seen) cram_rows <= ROW_W'(word) + ROW_W'(1);
                                    else           bram_rows <= ROW_W'(word) + ROW_W'(1);
                                    row_seen <= 1'b1;
                                end
                                OP_COL: begin
                                    if (!col_seen) cram_cols <= SIZE_W'(word);
                                    else           bram_cols <= SIZE_W'(word);
                                    col_seen <= 1'b1;
                                end
                                OP_WPTR: if (word == 16'h0000) wp_reset <= 1'b1;
                                OP_WARM: if ((word & 16'hFFDF) == '0) warm_boot <= word[5];
                                default: ;
                            endcase
                        end
                    end
                    ST_BURST: if (burst_last) trail_q <= '0;
                    ST_TRAIL: trail_q <= trail_q + TRAIL_W'(1);
                    default: ;
                endcase
            end
        end
    end

    AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cram_start && bram_start)); // R5
    AST_START_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cram_start || bram_start) |-> $past(in_valid)); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R14
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && $stable(err_code))); // R14
    AST_TERMINAL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !in_ready); // R14
    AST_DONE_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R14
    AST_FREQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        freq != 2'd3); // R8
endmodule

// File: tb/test_cfg_stream_parser.sv
module test_cfg_stream_parser;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, burst_last = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, burst_valid, cram_start, bram_start, wp_reset, done, error;
    logic [2:0] err_code;
    logic crc_fail, bank_bad, warm_boot;
    logic [15:0] crc_out, cram_cols, bram_cols;
    logic [16:0] cram_rows, bram_rows;
    logic [1:0] bank, freq;

    int checks = 0, errors = 0;
    logic [15:0] tb_crc = '0;
    logic bv_s;

    cfg_stream_parser i_cfg_stream_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .burst_last(burst_last),
        .burst_valid(burst_valid), .cram_start(cram_start), .bram_start(bram_start),
        .wp_reset(wp_reset), .done(done), .error(error), .err_code(err_code),
        .crc_fail(crc_fail), .bank_bad(bank_bad), .crc_out(crc_out), .bank(bank),
        .freq(freq), .warm_boot(warm_boot), .cram_rows(cram_rows), .cram_cols(cram_cols),
        .bram_rows(bram_rows), .bram_cols(bram_cols));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; burst_last = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tb_crc = '0;
    endtask

    task automatic send(input logic [7:0] b, input logic last = 1'b0, input logic blast = 1'b0);
        logic rdy;
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_last = last; burst_last = blast;
        #1;
        bv_s = burst_valid;
        rdy  = in_ready;
        @(posedge clk);
        if (rdy) tb_crc = model_crc(tb_crc, b);
        #1;
        in_valid = 1'b0; in_last = 1'b0; burst_last = 1'b0;
    endtask

    task automatic send_sync();
        send(8'h7E); send(8'hAA); send(8'h99); send(8'h7E);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R14 reset in_ready", in_ready, 1);
        chk("R14 reset done/error", {done, error, err_code}, 0);
        chk("R12 reset crc", crc_out, 0);
        chk("R7 reset bank", bank, 0);
    endtask

    task automatic t_hunt();
        do_reset();
        send(8'h11); send(8'h02);
        send(8'h7E); send(8'hAA); send(8'h99); send(8'h00);
        send_sync();
        chk("R1 no decode before sync", bank, 0);
        chk("R1 no error after sync", error, 0);
        send(8'h11); send(8'h02);
        chk("R2 bank command after sync", bank, 2);
        do_reset();
        send(8'h00); send(8'h7E); send(8'hAA, 1'b1);
        chk("R1 missing sync error", error, 1);
        chk("R1 missing sync code", err_code, 1);
    endtask

    task automatic t_config();
        do_reset();
        send_sync();
        send(8'h62); send(8'h01); send(8'h23);
        chk("R3 R9 cram_rows", cram_rows, 17'h0124);
        send(8'h62); send(8'h00); send(8'h07);
        chk("R9 bram_rows", bram_rows, 17'h0008);
        chk("R9 cram_rows kept", cram_rows, 17'h0124);
        send(8'h72); send(8'h00); send(8'h10);
        send(8'h72); send(8'h00); send(8'h20);
        chk("R9 cram_cols", cram_cols, 16'h0010);
        chk("R9 bram_cols", bram_cols, 16'h0020);
        send(8'h51); send(8'h02);
        chk("R8 freq high", freq, 2);
        send(8'h11); send(8'h07);
        chk("R7 bank low bits", bank, 3);
        chk("R7 bank_bad", bank_bad, 1);
        chk("R7 no error", error, 0);
        send(8'h92); send(8'h00); send(8'h20);
        chk("R11 warm_boot", warm_boot, 1);
        send(8'h82); send(8'h00); send(8'h00);
        chk("R10 wp_reset pulse", wp_reset, 1);
        send(8'h82); send(8'h00); send(8'h80);
        chk("R10 keep pointer", {wp_reset, error}, 0);
        chk("R12 crc running", crc_out, tb_crc);
    endtask

    task automatic t_comment();
        do_reset();
        send_sync();
        send(8'hFF); send(8'h00); send(8'h11); send(8'h03); send(8'h41); send(8'h00); send(8'hFF);
        chk("R4 comment body ignored", bank, 0);
        send(8'h11); send(8'h01);
        chk("R4 resume after comment", bank, 1);
        send(8'hFF); send(8'h00); send(8'hFF);
        send(8'h11); send(8'h02);
        chk("R4 empty comment", bank, 2);
        chk("R12 crc over comment", crc_out, tb_crc);
    endtask

    task automatic t_burst();
        int bv_cnt;
        do_reset();
        send_sync();
        send(8'h01); send(8'h01);
        chk("R5 cram_start", {cram_start, bram_start}, 2'b10);
        bv_cnt = 0;
        send(8'hD0); bv_cnt += bv_s;
        send(8'hD1); bv_cnt += bv_s;
        send(8'hD2, 1'b0, 1'b1); bv_cnt += bv_s;
        chk("R5 burst bytes flagged", bv_cnt, 3);
        chk("R5 start one cycle", cram_start, 0);
        send(8'h11); chk("R5 trailer not flagged", bv_s, 0);
        send(8'h03);
        chk("R5 trailer not decoded", bank, 0);
        send(8'h01); send(8'h03);
        chk("R5 bram_start", {cram_start, bram_start}, 2'b01);
        send(8'h55, 1'b0, 1'b1); send(8'h00); send(8'h00);
        send(8'h11); send(8'h01);
        chk("R5 back to commands", bank, 1);
        chk("R12 crc over burst", crc_out, tb_crc);
        send(8'h01); send(8'h06);
        chk("R6 wake done", done, 1);
        chk("R6 wake not ready", in_ready, 0);
        send(8'h11); send(8'h02);
        chk("R14 ignored after done", bank, 1);
        chk("R14 crc frozen", crc_out, tb_crc);
        chk("R14 done held", {done, error}, 2'b10);
    endtask

    task automatic t_crc();
        logic [15:0] snap;
        do_reset();
        send_sync();
        send(8'h01); send(8'h05);
        tb_crc = '0;
        chk("R6 crc cleared", crc_out, 0);
        send(8'h11); send(8'h00);
        snap = tb_crc;
        send(8'h22); send(snap[15:8]); send(snap[7:0]);
        chk("R13 matching check", crc_fail, 0);
        snap = tb_crc ^ 16'h0001;
        send(8'h22); send(snap[15:8]); send(snap[7:0]);
        chk("R13 mismatch flagged", crc_fail, 1);
        chk("R13 no error", error, 0);
        chk("R12 crc after checks", crc_out, tb_crc);
    endtask

    task automatic t_bad_one(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input int n, input logic [2:0] code);
        do_reset();
        send_sync();
        send(b0);
        if (n > 1) send(b1);
        if (n > 2) send(b2);
        chk(tag, {error, err_code}, {1'b1, code});
        chk("R14 not ready after error", in_ready, 0);
    endtask

    task automatic t_errors();
        t_bad_one("R2 bad length", 8'h63, 8'h00, 8'h00, 1, 3'd2);
        t_bad_one("R2 unknown opcode", 8'h31, 8'h00, 8'h00, 1, 3'd2);
        t_bad_one("R5 bad action", 8'h01, 8'h07, 8'h00, 2, 3'd3);
        t_bad_one("R8 bad freq", 8'h51, 8'h03, 8'h00, 2, 3'd4);
        t_bad_one("R10 bad pointer mode", 8'h82, 8'h00, 8'h01, 3, 3'd5);
        t_bad_one("R11 bad warm boot", 8'h92, 8'h00, 8'h01, 3, 3'd6);
        t_bad_one("R4 bad comment open", 8'hFF, 8'h01, 8'h00, 2, 3'd7);
        send(8'h11); send(8'h02);
        chk("R14 ignored after error", {bank, err_code}, {2'd0, 3'd7});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R14 watchdog act=hung exp=finished");
        summary();
    end

    initial begin
        t_reset_state();
        t_hunt();
        t_config();
        t_comment();
        t_burst();
        t_crc();
        t_errors();
        summary();
    end
endmodule